// File: doc/BRIEF.md
# Four-Rail Enable and Power-Good Sequencer

This block sits between four regulator rails and the rest of the chip. It takes one asynchronous enable per rail and, for each rail, two comparator flags: one that reports the output has climbed past its rising threshold (about 96% of target), and one that reports it has sagged below its falling threshold (about 93% of target). From these it decides when each rail may run, when the rail output is discharged, and when the rail is reported good. When every rail is off, it raises a shutdown flag.

Leaving shutdown costs a wake-up wait of `WAKE_US` microsecond ticks (420 by default) while references settle. A rail enabled while another rail is already up starts at once. Power-good has a minimum low time: every time it falls, it stays low until `PG_HOLD_MS` millisecond ticks (50 by default) have been counted. A fault supervisor may force power-good low per rail, which restarts that hold, or may disable a rail outright. Both timebases come in as single-cycle tick inputs.

The enable driver must keep each high pulse at least 1 ms and each low pulse at least 10 µs long. The block does not filter shorter pulses.

Top module: `rail_pg_ctrl`

## Requirements
- R1: After reset, every `pg_o` and `run_o` bit is 0, every `discharge_o` bit is 1 and `shutdown_o` is 1.
- R2: While `shutdown_o` is 1, an enable that goes high is synchronized through two flops. The controller then counts `WAKE_US` pulses of `tick_us_i` before it asserts `run_o` for that rail. `shutdown_o` drops in the same cycle that `run_o` rises.
- R3: While the controller is awake, a newly enabled rail's `run_o` rises two clock edges after its `en_i` rises, with no wake-up wait.
- R4: `pg_o[i]` rises on the clock edge after which `run_o[i]` and `above_rise_i[i]` are both 1, provided the hold time has expired.
- R5: While `pg_o[i]` is 1, `below_fall_i[i]` at a clock edge makes `pg_o[i]` 0 after that edge.
- R6: After `pg_o[i]` falls, it stays 0 until `PG_HOLD_MS` pulses of `tick_ms_i` have been counted, even if `above_rise_i[i]` is already 1.
- R7: Once a rail's synchronized enable is low, its `run_o` is 0 and its `discharge_o` is 1, and its `pg_o` is 0 after the next edge. `discharge_o[i]` is 1 exactly while that synchronized enable is low.
- R8: When all synchronized enables are low, `shutdown_o` returns to 1. The next enable pays the full wake-up wait again.
- R9: `force_low_i[i]` at an edge makes `pg_o[i]` 0 after that edge and restarts the `PG_HOLD_MS` hold count.
- R10: `rail_off_i[i]` forces `run_o[i]` to 0 in the same cycle, without a clock edge, and `pg_o[i]` to 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| en_i | input | N_RAIL | Asynchronous rail enables |
| above_rise_i | input | N_RAIL | Output above rising threshold |
| below_fall_i | input | N_RAIL | Output below falling threshold |
| force_low_i | input | N_RAIL | Supervisor request to force power-good low |
| rail_off_i | input | N_RAIL | Supervisor request to disable the rail |
| run_o | output | N_RAIL | Run request to each regulator |
| discharge_o | output | N_RAIL | Output pull-down control |
| pg_o | output | N_RAIL | Power-good per rail |
| shutdown_o | output | 1 | All rails off, low-current state |

## Verification
**Wake-up path.** A first enable from shutdown is compared with a second enable while the controller is awake. This separates the wake-up wait from the plain two-flop latency.

**Power-good pulses and hold timing.** Short dips of `below_fall_i` and `force_low_i` pulses are applied while `above_rise_i` stays high. This shows whether the hold time is enforced, and whether a force restarts it.

**Disables and full shutdown.** Single-rail disables are tried through the enable and through `rail_off_i`. Dropping every enable and then re-enabling checks that the wake-up wait is paid again.

// File: rtl/rail_pg_pkg.sv
package rail_pg_pkg;
  typedef enum logic [1:0] {
    WAKE_SLEEP = 2'd0,
    WAKE_WAIT  = 2'd1,
    WAKE_UP    = 2'd2
  } wake_state_e;
endpackage

// File: rtl/rail_pg_sync.sv
module rail_pg_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/rail_pg_wake.sv
module rail_pg_wake
  import rail_pg_pkg::*;
#(
  parameter int WAKE_US = 420
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_en_i,
  input  logic tick_us_i,
  output logic awake_o,
  output logic sleep_o
);
  localparam int CW = (WAKE_US > 1) ? $clog2(WAKE_US) : 1;

  wake_state_e st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= WAKE_SLEEP;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        WAKE_SLEEP: if (any_en_i) begin
          st_q  <= WAKE_WAIT;
          cnt_q <= '0;
        end
        WAKE_WAIT: begin
          if (!any_en_i) st_q <= WAKE_SLEEP;
          else if (tick_us_i) begin
            if (cnt_q == CW'(WAKE_US - 1)) st_q <= WAKE_UP;
            else cnt_q <= cnt_q + 1'b1;
          end
        end
        WAKE_UP: if (!any_en_i) st_q <= WAKE_SLEEP;
        default: st_q <= WAKE_SLEEP;
      endcase
    end
  end

  assign awake_o = (st_q == WAKE_UP);
  assign sleep_o = (st_q != WAKE_UP);
endmodule

// File: rtl/rail_pg_chan.sv
module rail_pg_chan #(
  parameter int PG_HOLD_MS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic above_i,
  input  logic below_i,
  input  logic force_i,
  input  logic tick_ms_i,
  output logic pg_o
);
  localparam int HW = $clog2(PG_HOLD_MS + 1);

  logic          pg_q, pg_n, hold_done;
  logic [HW-1:0] hold_q;

  assign hold_done = (hold_q == HW'(PG_HOLD_MS));

  always_comb begin
    if (!run_i || force_i) pg_n = 1'b0;
    else if (pg_q)         pg_n = !below_i;
    else                   pg_n = above_i && hold_done;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q   <= 1'b0;
      hold_q <= HW'(PG_HOLD_MS);
    end else begin
      pg_q <= pg_n;
      if ((pg_q && !pg_n) || force_i) hold_q <= '0;
      else if (tick_ms_i && !hold_done) hold_q <= hold_q + 1'b1;
    end
  end

  assign pg_o = pg_q;
endmodule

// File: rtl/rail_pg_ctrl.sv
module rail_pg_ctrl #(
  parameter int N_RAIL     = 4,
  parameter int WAKE_US    = 420,
  parameter int PG_HOLD_MS = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_us_i,
  input  logic              tick_ms_i,
  input  logic [N_RAIL-1:0] en_i,
  input  logic [N_RAIL-1:0] above_rise_i,
  input  logic [N_RAIL-1:0] below_fall_i,
  input  logic [N_RAIL-1:0] force_low_i,
  input  logic [N_RAIL-1:0] rail_off_i,
  output logic [N_RAIL-1:0] run_o,
  output logic [N_RAIL-1:0] discharge_o,
  output logic [N_RAIL-1:0] pg_o,
  output logic              shutdown_o
);
  logic [N_RAIL-1:0] en_s;
  logic              awake;

  rail_pg_sync #(.W(N_RAIL)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(en_i), .q_o(en_s)
  );

  rail_pg_wake #(.WAKE_US(WAKE_US)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .any_en_i(|en_s),
    .tick_us_i(tick_us_i), .awake_o(awake), .sleep_o(shutdown_o)
  );

  assign run_o       = en_s & {N_RAIL{awake}} & ~rail_off_i;
  assign discharge_o = ~en_s;

  for (genvar g = 0; g < N_RAIL; g++) begin : g_rail
    rail_pg_chan #(.PG_HOLD_MS(PG_HOLD_MS)) u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_o[g]),
      .above_i(above_rise_i[g]), .below_i(below_fall_i[g]),
      .force_i(force_low_i[g]), .tick_ms_i(tick_ms_i), .pg_o(pg_o[g])
    );
  end
endmodule

// File: rtl/rail_pg_ctrl_chk.sv
module rail_pg_ctrl_chk #(
  parameter int N_RAIL = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_RAIL-1:0] above_rise_i,
  input logic [N_RAIL-1:0] below_fall_i,
  input logic [N_RAIL-1:0] force_low_i,
  input logic [N_RAIL-1:0] run_o,
  input logic [N_RAIL-1:0] discharge_o,
  input logic [N_RAIL-1:0] pg_o,
  input logic              shutdown_o
);
  assert_shutdown_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> (run_o == '0));

  for (genvar g = 0; g < N_RAIL; g++) begin : g_chk
    assert_discharge_stopped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      discharge_o[g] |-> !run_o[g]);
    assert_pg_needs_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_o[g] |=> !pg_o[g]);
    assert_pg_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pg_o[g] && below_fall_i[g]) |=> !pg_o[g]);
    assert_force_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_low_i[g] |=> !pg_o[g]);
    assert_pg_rise_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pg_o[g]) |-> $past(above_rise_i[g]) && $past(run_o[g]));
  end
endmodule

bind rail_pg_ctrl rail_pg_ctrl_chk #(.N_RAIL(N_RAIL)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .above_rise_i(above_rise_i),
  .below_fall_i(below_fall_i), .force_low_i(force_low_i), .run_o(run_o),
  .discharge_o(discharge_o), .pg_o(pg_o), .shutdown_o(shutdown_o)
);

// File: tb/rail_pg_ctrl_test.sv
module rail_pg_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int WAKE = 420;
  localparam int HOLD = 50;

  logic clk = 0, rst_n = 0, tus = 0, tms = 0;
  logic [N-1:0] en = '0, above = '0, below = '0, frc = '0, roff = '0;
  logic [N-1:0] run, dis, pg;
  logic sd;
  int total = 0, bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_pg_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tus), .tick_ms_i(tms),
    .en_i(en), .above_rise_i(above), .below_fall_i(below),
    .force_low_i(frc), .rail_off_i(roff), .run_o(run), .discharge_o(dis),
    .pg_o(pg), .shutdown_o(sd)
  );

  // behavioural reference
  int s1[N], s2[N], mpg[N], mhold[N];
  int mode = 0, wcnt = 0;  // 0 off, 1 waiting, 2 up

  function automatic int exp_run(int i);
    return (s2[i] == 1 && mode == 2 && roff[i] == 0) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin s1[i] = 0; s2[i] = 0; mpg[i] = 0; mhold[i] = HOLD; end
      mode = 0; wcnt = 0;
    end else begin
      int any, nxt, r;
      any = 0;
      for (int i = 0; i < N; i++) if (s2[i] == 1) any = 1;
      for (int i = 0; i < N; i++) begin
        r = exp_run(i);
        if (r == 0 || frc[i]) nxt = 0;
        else if (mpg[i] == 1) nxt = below[i] ? 0 : 1;
        else nxt = (above[i] && mhold[i] >= HOLD) ? 1 : 0;
        if ((mpg[i] == 1 && nxt == 0) || frc[i]) mhold[i] = 0;
        else if (tms && mhold[i] < HOLD) mhold[i]++;
        mpg[i] = nxt;
      end
      if (mode == 0) begin if (any == 1) begin mode = 1; wcnt = 0; end end
      else if (any == 0) mode = 0;
      else if (mode == 1 && tus) begin
        wcnt++;
        if (wcnt >= WAKE) mode = 2;
      end
      for (int i = 0; i < N; i++) begin s2[i] = s1[i]; s1[i] = en[i]; end
    end
  end

  task automatic check(int act, int exp, string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < N; i++) begin
      check(int'(run[i]), exp_run(i), "R2/R3/R10 run vs model");
      check(int'(dis[i]), s2[i] == 1 ? 0 : 1, "R7 discharge vs model");
      check(int'(pg[i]), mpg[i], "R4/R5/R6 pg vs model");
    end
    check(int'(sd), mode == 2 ? 0 : 1, "R8 shutdown vs model");
  end

  // timebase ticks
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    tus = (cyc % 2 == 0);
    tms = (cyc % 10 == 0);
  end

  always @(posedge clk) if (cyc > 150000) begin
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic probe();
    @(negedge clk);
  endtask

  initial begin
    step(3);
    #2 rst_n = 1;
    probe();
    // R1 reset state
    check(int'(pg), 0, "R1 pg reset");
    check(int'(run), 0, "R1 run reset");
    check(int'(dis), 15, "R1 discharge reset");
    check(int'(sd), 1, "R1 shutdown reset");

    // R2 wake-up wait from shutdown
    step(1); en[0] = 1;
    step(400); probe();
    check(int'(run[0]), 0, "R2 still waiting");
    check(int'(sd), 1, "R2 shutdown during wait");
    step(500); probe();
    check(int'(run[0]), 1, "R2 run after wait");
    check(int'(sd), 0, "R2 awake");

    // R4 pg rise
    step(1); above[0] = 1;
    step(1); probe();
    check(int'(pg[0]), 1, "R4 pg rises");

    // R3 no wait when awake
    step(1); en[1] = 1; above[1] = 1;
    step(2); probe();
    check(int'(run[1]), 1, "R3 immediate run");

    // R5/R6 dip then hold
    step(5); below[0] = 1;
    step(1); below[0] = 0; probe();
    check(int'(pg[0]), 0, "R5 pg falls");
    step(300); probe();
    check(int'(pg[0]), 0, "R6 held low");
    step(300); probe();
    check(int'(pg[0]), 1, "R6 released after hold");

    // R9 force low restarts hold
    check(int'(pg[1]), 1, "R9 pg1 before force");
    step(1); frc[1] = 1;
    step(1); frc[1] = 0; probe();
    check(int'(pg[1]), 0, "R9 forced low");
    step(300); frc[1] = 1;
    step(1); frc[1] = 0;
    step(300); probe();
    check(int'(pg[1]), 0, "R9 hold restarted");
    step(300); probe();
    check(int'(pg[1]), 1, "R9 recovered");

    // R10 supervisor disable
    step(1); roff[1] = 1; #1;
    check(int'(run[1]), 0, "R10 run drops");
    step(1); probe();
    check(int'(pg[1]), 0, "R10 pg drops");
    step(1); roff[1] = 0;

    // R7 enable low
    step(1); en[0] = 0;
    step(2); probe();
    check(int'(dis[0]), 1, "R7 discharge on");
    check(int'(run[0]), 0, "R7 run off");
    step(1); probe();
    check(int'(pg[0]), 0, "R7 pg off");

    // R8 full shutdown and re-entry
    step(1); en = '0;
    step(3); probe();
    check(int'(sd), 1, "R8 shutdown");
    step(20); en[2] = 1;
    step(400); probe();
    check(int'(run[2]), 0, "R8 wait again");
    step(500); probe();
    check(int'(run[2]), 1, "R8 run after wait");

    step(10);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule